// File: doc/BRIEF.md
# Multiplexed-Bus Address Latch and Chip-Select Decoder

This block sits between an 8-bit processor's time-shared low address/data pins and the memory and I/O devices of a small system. While the address strobe is high, the low byte on the shared pins passes straight through to the address output and is also captured. Once the strobe drops, the captured byte is held, so the full 16-bit address stays stable while the same pins carry data.

The stable address is decoded, together with the memory/IO cycle-type input and the active-low read and write strobes, into active-low selects for a ROM (0000H-1FFFH), a RAM (2000H-3FFFH) and a bank of I/O ports. It also produces active-low gated read and write strobes for the memory side and for the I/O side. A device is enabled only when its range matches, the cycle type matches and exactly one strobe is low. A parameter switches the memory decode to partial mode, which ignores the top two address bits so that the ROM and RAM repeat every 16 KiB.

Top module: `addr_latch_decode`

## Requirements
- R1: While `ale` is 1, `addr[7:0]` equals `ad` in the same cycle and `addr[15:8]` always equals `a_hi`.
- R2: When `ale` is 0, `addr[7:0]` holds the `ad` value sampled at the last rising clock edge with `ale` at 1, whatever `ad` does afterwards.
- R3: In a memory cycle (`io_m`=0) with only `rd_n` low and the decoded address in 0000H-1FFFH, `rom_cs_n` and `mem_rd_n` are 0 and every other select and strobe output is 1.
- R4: In a memory cycle with exactly one strobe low and the decoded address in 2000H-3FFFH, `ram_cs_n` is 0, and `mem_rd_n` or `mem_wr_n` is 0 to match the strobe. All other outputs are 1.
- R5: With full decoding, a memory cycle at 4000H-FFFFH asserts no select and no strobe output.
- R6: A write cycle in the ROM range asserts no select and no strobe output; in particular `mem_wr_n` stays 1.
- R7: In an I/O cycle (`io_m`=1) with exactly one strobe low, `io_cs_n[k]` is 0 when `addr[7:0]` equals 40H+k (k from 0 to 3). `io_rd_n` or `io_wr_n` follows the strobe. No memory select or memory strobe is asserted, and a port number outside 40H-43H asserts nothing.
- R8: When neither strobe is low, or both are, every select and strobe output is 1.
- R9: All select and strobe outputs are active low, and at most one of `rom_cs_n`, `ram_cs_n` and `io_cs_n` is 0 at any time.
- R10: With partial decoding on, the memory decode uses only `addr[13:0]`, so an address A behaves like A AND 3FFFH for ROM/RAM selection.
- R11: While `rst_n` is 0, the held low byte is cleared and every select and strobe output is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the address strobe |
| rst_n | input | 1 | Active-low asynchronous reset |
| a_hi | input | 8 | High address byte from dedicated pins |
| ad | input | 8 | Shared low address / data pins |
| ale | input | 1 | Address strobe, high during the address phase |
| io_m | input | 1 | Cycle type: 1 = I/O, 0 = memory |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | output | 16 | Stable demultiplexed address |
| rom_cs_n | output | 1 | ROM select, active low |
| ram_cs_n | output | 1 | RAM select, active low |
| mem_rd_n | output | 1 | Gated memory read, active low |
| mem_wr_n | output | 1 | Gated memory write, active low |
| io_cs_n | output | 4 | Per-port I/O selects, active low |
| io_rd_n | output | 1 | Gated I/O read, active low |
| io_wr_n | output | 1 | Gated I/O write, active low |

## Verification
The low-byte hold and the decode act in the same cycle. In the data phase the decode must use the held byte while the shared pins carry a different value. The bench drives the bitwise complement of the captured byte onto `ad` during every strobe phase, so a decoder that read the live pins would select the wrong device or port. Every high byte is swept against a set of low bytes at the range and port edges, under all four strobe patterns and both cycle types. The address and every select are compared with values computed arithmetically for a full-decode and a partial-decode instance.

// File: rtl/addr_latch_decode.sv
module addr_latch_decode #(
  parameter int AW        = 16,
  parameter int LW        = 8,
  parameter int ROM_LO    = 'h0000,
  parameter int ROM_HI    = 'h1FFF,
  parameter int RAM_LO    = 'h2000,
  parameter int RAM_HI    = 'h3FFF,
  parameter int N_PORTS   = 4,
  parameter int IO_BASE   = 'h40,
  parameter bit PARTIAL   = 1'b0,
  parameter int PART_BITS = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-LW-1:0]   a_hi,
  input  logic [LW-1:0]      ad,
  input  logic               ale,
  input  logic               io_m,
  input  logic               rd_n,
  input  logic               wr_n,
  output logic [AW-1:0]      addr,
  output logic               rom_cs_n,
  output logic               ram_cs_n,
  output logic               mem_rd_n,
  output logic               mem_wr_n,
  output logic [N_PORTS-1:0] io_cs_n,
  output logic               io_rd_n,
  output logic               io_wr_n
);

  localparam logic [AW-1:0] DEC_MASK = PARTIAL ?
    {{(AW-PART_BITS){1'b0}}, {PART_BITS{1'b1}}} : {AW{1'b1}};
  localparam logic [AW-1:0] ROM_BASE = ROM_LO[AW-1:0];
  localparam logic [AW-1:0] ROM_SPAN = ROM_HI[AW-1:0] - ROM_LO[AW-1:0];
  localparam logic [AW-1:0] RAM_BASE = RAM_LO[AW-1:0];
  localparam logic [AW-1:0] RAM_SPAN = RAM_HI[AW-1:0] - RAM_LO[AW-1:0];

  logic [LW-1:0] lo_held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   lo_held <= '0;
    else if (ale) lo_held <= ad;
  end

  assign addr = {a_hi, ale ? ad : lo_held};

  logic [AW-1:0] dec_addr, rom_off, ram_off;
  logic rd_act, wr_act, xfer, in_rom, in_ram, rom_sel, ram_sel;

  assign dec_addr = addr & DEC_MASK;
  assign rom_off  = dec_addr - ROM_BASE;
  assign ram_off  = dec_addr - RAM_BASE;
  assign in_rom   = rom_off <= ROM_SPAN;
  assign in_ram   = (ram_off <= RAM_SPAN) && !in_rom;

  assign rd_act = rst_n && !rd_n && wr_n;
  assign wr_act = rst_n && rd_n && !wr_n;
  assign xfer   = rd_act || wr_act;

  assign rom_sel = !io_m && rd_act && in_rom;
  assign ram_sel = !io_m && xfer && in_ram;

  assign rom_cs_n = !rom_sel;
  assign ram_cs_n = !ram_sel;
  assign mem_rd_n = !((rom_sel || ram_sel) && rd_act);
  assign mem_wr_n = !(ram_sel && wr_act);

  logic [N_PORTS-1:0] port_hit;

  for (genvar k = 0; k < N_PORTS; k++) begin : g_port
    localparam logic [LW-1:0] PNUM = LW'(IO_BASE + k);
    assign port_hit[k] = io_m && xfer && (addr[LW-1:0] == PNUM);
  end

  assign io_cs_n = ~port_hit;
  assign io_rd_n = !((|port_hit) && rd_act);
  assign io_wr_n = !((|port_hit) && wr_act);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> (!ale -> addr[LW-1:0] == $past(ad)));

  assert_one_select_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({~rom_cs_n, ~ram_cs_n, ~io_cs_n}));

  assert_rom_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_cs_n |-> (wr_n && mem_wr_n));

  assert_io_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    io_m |-> (rom_cs_n && ram_cs_n && mem_rd_n && mem_wr_n));

  assert_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_n == wr_n) |-> (&{rom_cs_n, ram_cs_n, mem_rd_n, mem_wr_n,
                          io_rd_n, io_wr_n, io_cs_n}));

  assert_ram_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wr_n |-> (!ram_cs_n && !wr_n && !io_m));

endmodule

// File: tb/tb_addr_latch_decode.sv
module tb_addr_latch_decode;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic [7:0] a_hi = 8'h00, ad = 8'h00;
  logic       ale = 1'b0, io_m = 1'b0, rd_n = 1'b0, wr_n = 1'b1;

  logic [15:0] addr_f, addr_p;
  logic rom_f, ram_f, mrd_f, mwr_f, iord_f, iowr_f;
  logic rom_p, ram_p, mrd_p, mwr_p, iord_p, iowr_p;
  logic [3:0] ios_f, ios_p;

  addr_latch_decode dut (
    .clk(clk), .rst_n(rst_n), .a_hi(a_hi), .ad(ad), .ale(ale), .io_m(io_m),
    .rd_n(rd_n), .wr_n(wr_n), .addr(addr_f), .rom_cs_n(rom_f), .ram_cs_n(ram_f),
    .mem_rd_n(mrd_f), .mem_wr_n(mwr_f), .io_cs_n(ios_f), .io_rd_n(iord_f),
    .io_wr_n(iowr_f));

  addr_latch_decode #(.PARTIAL(1'b1)) dut_p (
    .clk(clk), .rst_n(rst_n), .a_hi(a_hi), .ad(ad), .ale(ale), .io_m(io_m),
    .rd_n(rd_n), .wr_n(wr_n), .addr(addr_p), .rom_cs_n(rom_p), .ram_cs_n(ram_p),
    .mem_rd_n(mrd_p), .mem_wr_n(mwr_p), .io_cs_n(ios_p), .io_rd_n(iord_p),
    .io_wr_n(iowr_p));

  int errors = 0;
  int checks = 0;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h time=%0t", req, act, exp, $time);
    end
  endtask

  // order: rom, ram, mem_rd, mem_wr, io_rd, io_wr, io_cs[3:0]
  function automatic logic [9:0] expect_out(input logic [15:0] a, input logic iom,
                                             input logic rdn, input logic wrn,
                                             input logic part);
    logic rd, wr, one, rom, ram;
    logic [15:0] ea;
    logic [3:0] hit;
    rd  = !rdn && wrn;
    wr  = rdn && !wrn;
    one = rd || wr;
    ea  = part ? (a & 16'h3FFF) : a;
    rom = !iom && rd && (ea <= 16'h1FFF);
    ram = !iom && one && (ea >= 16'h2000) && (ea <= 16'h3FFF);
    for (int k = 0; k < 4; k++) hit[k] = iom && one && (a[7:0] == 8'(8'h40 + k));
    return ~{rom, ram, (rom || ram) && rd, ram && wr, (|hit) && rd, (|hit) && wr, hit};
  endfunction

  function automatic string tag(input logic [15:0] a, input logic iom, input int mode,
                                input logic part);
    if (mode >= 2) return "R8";
    if (iom) return "R7";
    if (part) return "R10";
    if (a >= 16'h4000) return "R5";
    if (a <= 16'h1FFF) return (mode == 1) ? "R6" : "R3";
    return "R4";
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] lows [6];
    lows = '{8'h00, 8'h3F, 8'h40, 8'h41, 8'h43, 8'hFF};

    // R11: reset state with a read strobe already present
    repeat (2) @(negedge clk);
    #2;
    chk("R11 selects in reset", {6'd0, rom_f, ram_f, mrd_f, mwr_f, iord_f, iowr_f, ios_f}, 16'h03FF);
    chk("R11 held byte cleared", addr_f, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    rd_n  = 1'b1;

    for (int h = 0; h < 256; h++) begin
      for (int li = 0; li < 6; li++) begin
        for (int iom = 0; iom < 2; iom++) begin
          for (int mode = 0; mode < 4; mode++) begin
            logic [15:0] a;
            logic rdn, wrn;
            a = {8'(h), lows[li]};
            rdn = !(mode == 0 || mode == 3);
            wrn = !(mode == 1 || mode == 3);
            @(negedge clk);
            ale = 1'b1; a_hi = 8'(h); ad = lows[li]; io_m = 1'(iom);
            rd_n = 1'b1; wr_n = 1'b1;
            #2;
            if (mode == 0) chk("R1 address pass-through", addr_f, a);
            @(negedge clk);
            ale = 1'b0; ad = ~lows[li]; rd_n = rdn; wr_n = wrn;
            #2;
            chk("R2 held low byte", addr_f, a);
            chk({tag(a, 1'(iom), mode, 1'b0), " full decode"},
                {6'd0, rom_f, ram_f, mrd_f, mwr_f, iord_f, iowr_f, ios_f},
                {6'd0, expect_out(a, 1'(iom), rdn, wrn, 1'b0)});
            chk({tag(a, 1'(iom), mode, 1'b1), " partial decode"},
                {6'd0, rom_p, ram_p, mrd_p, mwr_p, iord_p, iowr_p, ios_p},
                {6'd0, expect_out(a, 1'(iom), rdn, wrn, 1'b1)});
            chk("R9 at most one select",
                16'($countones({~rom_f, ~ram_f, ~ios_f}) <= 1), 16'd1);
          end
        end
      end
    end

    // R11: reset mid-cycle clears held byte and forces outputs high
    @(negedge clk);
    ale = 1'b1; a_hi = 8'h25; ad = 8'h77; io_m = 1'b0; rd_n = 1'b1; wr_n = 1'b1;
    @(negedge clk);
    ale = 1'b0; ad = 8'h11; rd_n = 1'b0; rst_n = 1'b0;
    #2;
    chk("R11 reset clears held byte", addr_f, 16'h2500);
    chk("R11 reset outputs high", {6'd0, rom_f, ram_f, mrd_f, mwr_f, iord_f, iowr_f, ios_f}, 16'h03FF);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule